// File: doc/BRIEF.md
# Synchronous RAM Read-Port Emulation Wrapper

This block sits around a plain synchronous-read RAM. That RAM only registers the word at the read address. It has no reset value on its read register, no power-up value, and it does not pass a write through to a read at the same address. The wrapper adds all three behaviours. It keeps two registers beside the RAM: a shadow word and a per-bit select word. For each output bit, the select word decides whether the bit comes from the shadow word or straight from the RAM output.

There is one clock, one masked write port and one read port. The read port has an enable, a synchronous reset and an asynchronous clear. The write port is narrower than the read word by a power-of-two ratio, or equal to it. The low write-address bits pick the lane inside a read word, and the write data and mask are shifted into that lane. The same shifted values feed both the RAM and the forwarding path. Ordering between synchronous reset and enable is a parameter. An active-low power-on reset loads the configured power-up value and is released synchronously inside the block.

Top module: `sram_rdport_wrap`

## Requirements
- R1: A write to write address A changes only read word A>>LANE_LOG2. Inside that word it changes only lane A[LANE_LOG2-1:0], which covers bits lane*WR_W upward. Within the lane, only the bits whose mask bit is 1 take the write data.
- R2: With rd_en high and no reset in effect, rd_data shows the word at rd_addr one clock edge later.
- R3: When an enabled read and a write target the same read word in the same cycle, the masked bits of the write lane show the new write data. All other bits show the contents from before the write.
- R4: With rd_en low and no synchronous reset in effect, rd_data holds its value.
- R5: With the default ordering, rd_srst loads RST_VAL onto rd_data at the next edge whatever rd_en is.
- R6: With enable-over-reset ordering, rd_srst has no effect while rd_en is low. When rd_en is high it loads RST_VAL.
- R7: rd_clr high forces rd_data to CLR_VAL at once, and holds it there while rd_clr stays high.
- R8: After rst_n is released, rd_data shows INIT_VAL (when HAS_INIT is 1) until the first effective read or reset.
- R9: After a reset or clear value is shown, the next enabled read shows RAM data again.
- R10: A write to a different read word does not change the word returned by a read issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both ports |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously |
| wr_en | input | 1 | Write request |
| wr_addr | input | RD_AW+LANE_LOG2 | Write address in write-word units |
| wr_data | input | WR_W | Write data |
| wr_mask | input | WR_W | Per-bit write mask, 1 = write the bit |
| rd_en | input | 1 | Read enable |
| rd_addr | input | RD_AW | Read word address |
| rd_srst | input | 1 | Synchronous read reset |
| rd_clr | input | 1 | Asynchronous read clear, active high |
| rd_data | output | RD_W | Read data |

## Verification
The assertions assume that rd_clr changes only away from the active edge and is held over at least one edge. They also assume that rst_n is released only once, after time zero, and that no address is read before it has been written. The stimulus meets these assumptions as follows:
- All inputs change on the falling edge.
- The clear is held across a rising edge before it is released.
- Every row is written in full before the first read.

Random traffic forces the read address onto the write row about half the time, so that lane forwarding under mixed masks is exercised often.

// File: rtl/sram_rdport_pkg.sv
package sram_rdport_pkg;
  typedef enum logic {
    PRIO_RESET  = 1'b0,
    PRIO_ENABLE = 1'b1
  } rd_prio_e;
endpackage

// File: rtl/sram_lane_align.sv
module sram_lane_align #(
  parameter int RD_W      = 16,
  parameter int LANE_LOG2 = 1,
  parameter int RD_AW     = 4,
  localparam int WR_W     = RD_W >> LANE_LOG2,
  localparam int WR_AW    = RD_AW + LANE_LOG2
) (
  input  logic [WR_AW-1:0] wr_addr,
  input  logic [WR_W-1:0]  wr_data,
  input  logic [WR_W-1:0]  wr_mask,
  output logic [RD_AW-1:0] row,
  output logic [RD_W-1:0]  data_wide,
  output logic [RD_W-1:0]  mask_wide
);
  generate
    if (LANE_LOG2 == 0) begin : g_same
      assign row       = wr_addr;
      assign data_wide = wr_data;
      assign mask_wide = wr_mask;
    end else begin : g_narrow
      logic [LANE_LOG2-1:0] lane;
      assign lane      = wr_addr[LANE_LOG2-1:0];
      assign row       = wr_addr[WR_AW-1:LANE_LOG2];
      assign data_wide = RD_W'(wr_data) << (lane * WR_W);
      assign mask_wide = RD_W'(wr_mask) << (lane * WR_W);
    end
  endgenerate

  // R1: shifting into a lane neither drops nor adds mask bits
  always_comb begin
    assert_lane_bits_R1: assert ($countones(mask_wide) == $countones(wr_mask));
  end
endmodule

// File: rtl/sram_core.sv
module sram_core #(
  parameter int W     = 16,
  parameter int AW    = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic [W-1:0]  wmask,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  q
);
  logic [W-1:0] mem_q [DEPTH];
  logic [W-1:0] row_d;
  logic [W-1:0] q_d;

  always_comb begin
    row_d = (mem_q[waddr] & ~wmask) | (wdata & wmask);
    q_d   = re ? mem_q[raddr] : q;
  end

  always_ff @(posedge clk) begin
    mem_q[waddr] <= row_d;
    q            <= q_d;
  end
endmodule

// File: rtl/sram_rd_shadow.sv
module sram_rd_shadow
  import sram_rdport_pkg::*;
#(
  parameter int       W        = 16,
  parameter rd_prio_e PRIO     = PRIO_RESET,
  parameter logic [W-1:0] RST_VAL  = '0,
  parameter logic [W-1:0] CLR_VAL  = '0,
  parameter logic [W-1:0] INIT_VAL = '0,
  parameter bit       HAS_INIT = 1'b1
) (
  input  logic         clk,
  input  logic         arst,
  input  logic         clr,
  input  logic         srst,
  input  logic         en,
  input  logic         hit,
  input  logic [W-1:0] fwd_data,
  input  logic [W-1:0] fwd_mask,
  output logic [W-1:0] shadow,
  output logic [W-1:0] sel
);
  localparam logic [W-1:0] SEL_PWRUP = {W{HAS_INIT}};
  localparam logic [W-1:0] SHD_PWRUP = HAS_INIT ? INIT_VAL : '0;

  logic         do_rst;
  logic         do_ld;
  logic [W-1:0] shadow_d;
  logic [W-1:0] sel_d;

  always_comb begin
    do_rst   = srst && ((PRIO == PRIO_RESET) || en);
    do_ld    = en && !srst;
    shadow_d = shadow;
    sel_d    = sel;
    if (do_rst) begin
      shadow_d = RST_VAL;
      sel_d    = '1;
    end else if (do_ld) begin
      sel_d    = hit ? fwd_mask : '0;
      shadow_d = fwd_data & sel_d;
    end
  end

  always_ff @(posedge clk or posedge arst or posedge clr) begin
    if (arst) begin
      shadow <= SHD_PWRUP;
      sel    <= SEL_PWRUP;
    end else if (clr) begin
      shadow <= CLR_VAL;
      sel    <= '1;
    end else begin
      shadow <= shadow_d;
      sel    <= sel_d;
    end
  end

  // R9: a read without address match hands every bit back to the RAM
  assert_sel_release_R9: assert property (@(posedge clk) disable iff (arst || clr)
    (en && !srst && !hit) |=> (sel == '0));
  // R5: reset-first ordering forces full shadow selection
  assert_srst_sel_R5: assert property (@(posedge clk) disable iff (arst || clr)
    (srst && (PRIO == PRIO_RESET)) |=> (&sel));
endmodule

// File: rtl/sram_rdport_wrap.sv
module sram_rdport_wrap
  import sram_rdport_pkg::*;
#(
  parameter int       RD_W      = 16,
  parameter int       LANE_LOG2 = 1,
  parameter int       RD_AW     = 4,
  parameter rd_prio_e RD_PRIO   = PRIO_RESET,
  parameter logic [RD_W-1:0] RST_VAL  = 16'hA5C3,
  parameter logic [RD_W-1:0] CLR_VAL  = 16'h5A3C,
  parameter logic [RD_W-1:0] INIT_VAL = 16'hC0DE,
  parameter bit       HAS_INIT  = 1'b1,
  localparam int WR_W  = RD_W >> LANE_LOG2,
  localparam int WR_AW = RD_AW + LANE_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WR_AW-1:0] wr_addr,
  input  logic [WR_W-1:0]  wr_data,
  input  logic [WR_W-1:0]  wr_mask,
  input  logic             rd_en,
  input  logic [RD_AW-1:0] rd_addr,
  input  logic             rd_srst,
  input  logic             rd_clr,
  output logic [RD_W-1:0]  rd_data
);
  logic [1:0]       rst_sync_q;
  logic             arst;
  logic [RD_AW-1:0] wr_row;
  logic [RD_W-1:0]  data_wide;
  logic [RD_W-1:0]  mask_wide;
  logic [RD_W-1:0]  ram_mask;
  logic             hit;
  logic [RD_W-1:0]  ram_q;
  logic [RD_W-1:0]  shadow;
  logic [RD_W-1:0]  sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign arst = !rst_sync_q[1];

  sram_lane_align #(.RD_W(RD_W), .LANE_LOG2(LANE_LOG2), .RD_AW(RD_AW)) u_align (
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_mask  (wr_mask),
    .row      (wr_row),
    .data_wide(data_wide),
    .mask_wide(mask_wide)
  );

  assign ram_mask = mask_wide & {RD_W{wr_en}};
  assign hit      = wr_en && (wr_row == rd_addr);

  sram_core #(.W(RD_W), .AW(RD_AW)) u_core (
    .clk  (clk),
    .wmask(ram_mask),
    .waddr(wr_row),
    .wdata(data_wide),
    .re   (rd_en),
    .raddr(rd_addr),
    .q    (ram_q)
  );

  sram_rd_shadow #(
    .W(RD_W), .PRIO(RD_PRIO), .RST_VAL(RST_VAL), .CLR_VAL(CLR_VAL),
    .INIT_VAL(INIT_VAL), .HAS_INIT(HAS_INIT)
  ) u_shadow (
    .clk     (clk),
    .arst    (arst),
    .clr     (rd_clr),
    .srst    (rd_srst),
    .en      (rd_en),
    .hit     (hit),
    .fwd_data(data_wide),
    .fwd_mask(mask_wide),
    .shadow  (shadow),
    .sel     (sel)
  );

  assign rd_data = (sel & shadow) | (~sel & ram_q);

  // R3: masked bits of a same-row write appear on the read port
  assert_fwd_R3: assert property (@(posedge clk) disable iff (arst || rd_clr)
    (rd_en && !rd_srst && hit) |=>
      ((rd_data & $past(mask_wide)) == ($past(data_wide) & $past(mask_wide))));
  // R4: idle read port holds its output
  assert_hold_R4: assert property (@(posedge clk) disable iff (arst || rd_clr)
    (!rd_en && (!rd_srst || (RD_PRIO == PRIO_ENABLE))) |=> $stable(rd_data));
  // R7: clear dominates the output
  assert_clear_R7: assert property (@(posedge clk) disable iff (arst)
    rd_clr |-> (rd_data == CLR_VAL));
  // R5/R6: effective synchronous reset shows the reset word
  assert_srst_R5: assert property (@(posedge clk) disable iff (arst || rd_clr)
    (rd_srst && ((RD_PRIO == PRIO_RESET) || rd_en)) |=> (rd_data == RST_VAL));
endmodule

// File: tb/sram_rdport_wrap_test.sv
module sram_rdport_wrap_test;
  import sram_rdport_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int RD_W = 16;
  localparam int WR_W = 8;
  localparam logic [15:0] RST_V  = 16'hA5C3;
  localparam logic [15:0] CLR_V  = 16'h5A3C;
  localparam logic [15:0] INIT_V = 16'hC0DE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] wr_mask = '0;
  logic rd_en = 1'b0;
  logic [3:0] rd_addr = '0;
  logic rd_srst = 1'b0;
  logic rd_clr = 1'b0;
  logic [15:0] rd_data_a;
  logic [15:0] rd_data_b;

  logic [15:0] mem_m [16];
  logic [15:0] exp_a;
  logic [15:0] exp_b;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_rdport_wrap uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_mask(wr_mask), .rd_en(rd_en), .rd_addr(rd_addr), .rd_srst(rd_srst),
    .rd_clr(rd_clr), .rd_data(rd_data_a));

  sram_rdport_wrap #(.RD_PRIO(PRIO_ENABLE)) uut_en (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_mask(wr_mask), .rd_en(rd_en), .rd_addr(rd_addr), .rd_srst(rd_srst),
    .rd_clr(rd_clr), .rd_data(rd_data_b));

  function automatic logic [15:0] place(input logic [7:0] v, input logic lane);
    return 16'(v) << (lane ? WR_W : 0);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  // inputs are set at a falling edge before calling
  task automatic cycle(input string req_a, input string req_b);
    logic [15:0] wm, wd, nxt, na, nb;
    wm  = wr_en ? place(wr_mask, wr_addr[0]) : 16'h0;
    wd  = place(wr_data, wr_addr[0]);
    nxt = mem_m[rd_addr];
    if (wr_addr[4:1] == rd_addr) nxt = (nxt & ~wm) | (wd & wm);
    na = exp_a;
    if (rd_srst) na = RST_V;
    else if (rd_en) na = nxt;
    nb = exp_b;
    if (rd_en) nb = rd_srst ? RST_V : nxt;
    @(posedge clk);
    mem_m[wr_addr[4:1]] = (mem_m[wr_addr[4:1]] & ~wm) | (wd & wm);
    exp_a = na;
    exp_b = nb;
    @(negedge clk);
    chk(req_a, rd_data_a, exp_a);
    chk(req_b, rd_data_b, exp_b);
  endtask

  task automatic set_in(input logic we, input logic [4:0] wa, input logic [7:0] wdv,
                        input logic [7:0] wmv, input logic re, input logic [3:0] ra,
                        input logic sr);
    wr_en = we; wr_addr = wa; wr_data = wdv; wr_mask = wmv;
    rd_en = re; rd_addr = ra; rd_srst = sr;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem_m[i] = 16'h0;
    exp_a = INIT_V;
    exp_b = INIT_V;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R8: power-up word after release
    chk("R8", rd_data_a, INIT_V);
    chk("R8", rd_data_b, INIT_V);

    // prefill every row with read disabled; output must hold (R4)
    for (int a = 0; a < 32; a++) begin
      set_in(1'b1, 5'(a), 8'(a * 37 + 5), 8'hFF, 1'b0, 4'(a), 1'b0);
      cycle("R4", "R4");
    end

    // R1: masked lane write, then read back
    set_in(1'b1, 5'd11, 8'hAB, 8'h0F, 1'b0, 4'd0, 1'b0);
    cycle("R4", "R4");
    set_in(1'b0, 5'd0, 8'h00, 8'h00, 1'b1, 4'd5, 1'b0);
    cycle("R1", "R1");
    set_in(1'b0, 5'd0, 8'h00, 8'h00, 1'b1, 4'd3, 1'b0);
    cycle("R2", "R2");

    // R3: write-through on the same row, lane 0, upper nibble
    set_in(1'b1, 5'd14, 8'h9C, 8'hF0, 1'b1, 4'd7, 1'b0);
    cycle("R3", "R3");
    // R3: lane 1 full mask
    set_in(1'b1, 5'd15, 8'h3E, 8'hFF, 1'b1, 4'd7, 1'b0);
    cycle("R3", "R3");

    // R10: write elsewhere while reading
    set_in(1'b1, 5'd4, 8'h77, 8'hFF, 1'b1, 4'd9, 1'b0);
    cycle("R10", "R10");

    // R5 / R6: sync reset with read disabled
    set_in(1'b0, 5'd0, 8'h00, 8'h00, 1'b0, 4'd9, 1'b1);
    cycle("R5", "R6");
    set_in(1'b0, 5'd0, 8'h00, 8'h00, 1'b1, 4'd9, 1'b1);
    cycle("R5", "R6");
    set_in(1'b0, 5'd0, 8'h00, 8'h00, 1'b1, 4'd2, 1'b0);
    cycle("R9", "R9");

    // R7: asynchronous clear
    set_in(1'b0, 5'd0, 8'h00, 8'h00, 1'b1, 4'd6, 1'b0);
    rd_clr = 1'b1;
    #1;
    chk("R7", rd_data_a, CLR_V);
    chk("R7", rd_data_b, CLR_V);
    @(negedge clk);
    chk("R7", rd_data_a, CLR_V);
    chk("R7", rd_data_b, CLR_V);
    rd_clr = 1'b0;
    rd_en = 1'b0;
    exp_a = CLR_V;
    exp_b = CLR_V;
    cycle("R7", "R7");
    set_in(1'b0, 5'd0, 8'h00, 8'h00, 1'b1, 4'd6, 1'b0);
    cycle("R9", "R9");

    // random traffic, fixed seed
    void'($urandom(32'd20240611));
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] wa;
      logic [3:0] ra;
      logic we, re, sr;
      string ta, tb;
      wa = 5'($urandom);
      ra = ($urandom_range(1) == 1) ? wa[4:1] : 4'($urandom);
      we = ($urandom_range(3) != 0);
      re = ($urandom_range(4) != 0);
      sr = ($urandom_range(19) == 0);
      set_in(we, wa, 8'($urandom), 8'($urandom), re, ra, sr);
      if (sr) ta = "R5";
      else if (re && we && wa[4:1] == ra) ta = "R3";
      else if (re && we) ta = "R10";
      else if (re) ta = "R2";
      else ta = "R4";
      tb = (sr && !re) ? "R6" : ta;
      cycle(ta, tb);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule